// File: doc/BRIEF.md
# Packed Rounding Multiply-High Unit

This block is a SIMD multiply-high datapath. It cuts two packed operand words into equal lanes of 16 or 32 bits and multiplies each pair of lanes at full double width. When rounding is requested, it adds a half-LSB bias to each product. It then returns the upper half of every lane product, packed back into one word. Lanes never interact.

Each lane can treat its inputs as signed by signed, unsigned by unsigned, or signed by unsigned. The mixed mode is asymmetric: the signed factor always comes from the first operand. A caller that holds its operands the other way round must swap them before issuing.

The result and an illegal-configuration flag are registered once, so both appear one clock after the inputs are captured. The datapath width is a parameter. With a 32-bit word, only 16-bit lanes are legal.

Top module: `pmulh_round_unit`

## Requirements
- R1: With `lane32_i`=0, lane k occupies bits [16k+15:16k] of `op_a_i`, `op_b_i` and `result_o`. The word holds XLEN/16 lanes, and a lane's result depends only on that lane's inputs.
- R2: With `lane32_i`=1 on a 64-bit datapath, the word holds two lanes of 32 bits, at bits [31:0] and [63:32].
- R3: `mode_i`=2'b00 treats both lane inputs as two's-complement signed values.
- R4: `mode_i`=2'b01 treats both lane inputs as unsigned values.
- R5: `mode_i`=2'b10 treats the `op_a_i` lane as signed and the `op_b_i` lane as unsigned. Swapping the operands generally changes the result.
- R6: With `round_i`=1, each lane adds 2^(W-1) to its 2W-bit product before taking bits [2W-1:W]. A product whose low half is exactly 2^(W-1) therefore rounds up by one.
- R7: With `round_i`=0, each lane returns bits [2W-1:W] of the exact product, which truncates toward minus infinity.
- R8: The biased sum is formed in 2W bits and never overflows. For 16-bit lanes, rounded signed 0x8000×0x8000 gives 0x4000, and rounded unsigned 0xFFFF×0xFFFF gives 0xFFFE.
- R9: `result_o` and `illegal_o` change only on a rising clock edge. They reflect the inputs present at that edge.
- R10: While `rst_n` is low at a rising edge, `result_o` becomes 0 and `illegal_o` becomes 0.
- R11: `mode_i`=2'b11, or `lane32_i`=1 on a 32-bit datapath, is illegal. It gives `illegal_o`=1 and `result_o`=0.
- R12: A legal operation with `op_a_i` equal to zero gives a zero result in every mode, with or without rounding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a_i | input | XLEN | First packed operand (signed side in mixed mode) |
| op_b_i | input | XLEN | Second packed operand |
| lane32_i | input | 1 | Lane width select: 0 = 16-bit lanes, 1 = 32-bit lanes |
| mode_i | input | 2 | Signedness: 00 signed, 01 unsigned, 10 signed×unsigned, 11 illegal |
| round_i | input | 1 | Add the half-LSB bias before taking the high half |
| result_o | output | XLEN | Packed high halves of the lane products |
| illegal_o | output | 1 | Registered flag for an illegal configuration |

## Verification
Random operands are applied in every mode, at both lane widths and with rounding on and off. These runs separate a wrong lane extension, a wrong lane slice or a misplaced bias from the correct result, lane by lane.

Directed patterns cover the following:
- the most negative value squared, and all-ones squared in unsigned mode, which probe the top of the 2W-bit sum;
- a product whose low half sits exactly on the rounding threshold, which separates the rounded result from the truncated one;
- swapped operands in mixed mode, which expose a commuted implementation;
- zero operands.

A second instance with a 32-bit datapath shows the illegal width being rejected, and an early-sampling check shows the one-cycle latency.

// File: rtl/pmulh_pkg.sv
// Package: shared encodings for the packed multiply-high unit.
// Assumes: the mode encoding is fixed by the issuing logic upstream.
package pmulh_pkg;

    typedef enum logic [1:0] {
        MODE_SS   = 2'b00,
        MODE_UU   = 2'b01,
        MODE_SU   = 2'b10,
        MODE_RSVD = 2'b11
    } sign_mode_e;

    // First operand lane is signed in signed and mixed modes
    function automatic logic a_is_signed(sign_mode_e m);
        return (m == MODE_SS) || (m == MODE_SU);
    endfunction

    // Second operand lane is signed only in signed mode
    function automatic logic b_is_signed(sign_mode_e m);
        return (m == MODE_SS);
    endfunction

endpackage

// File: rtl/pmulh_lane.sv
// Module: one multiply-high lane of width W.
// Each factor is widened by one bit, as sign or zero according to its flag.
// The product is formed as a signed 2W+2-bit value, the optional bias
// 2^(W-1) is added, and bits [2W-1:W] are returned.
// Assumes: purely combinational; the caller registers the output.
module pmulh_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         a_sgn_i,
    input  logic         b_sgn_i,
    input  logic         rnd_i,
    output logic [W-1:0] hi_o
);
    localparam int PW = 2 * W + 2;

    logic signed [W:0]    a_ext;
    logic signed [W:0]    b_ext;
    logic signed [PW-1:0] prod;
    logic        [PW-1:0] bias;
    logic        [PW-1:0] sum;

    // Widen, multiply, bias and extract the high half of this lane
    always_comb begin
        a_ext = {a_sgn_i & a_i[W-1], a_i};
        b_ext = {b_sgn_i & b_i[W-1], b_i};
        prod  = PW'(a_ext) * PW'(b_ext);
        bias  = rnd_i ? (PW'(1) << (W - 1)) : '0;
        sum   = prod + bias;
        hi_o  = W'(sum >> W);
    end

endmodule

// File: rtl/pmulh_bank.sv
// Module: a bank of XLEN/W multiply-high lanes sharing one control set.
// Lane k reads and writes bits [k*W +: W]; no signal crosses lanes.
// Assumes: XLEN is a multiple of W.
module pmulh_bank #(
    parameter int XLEN = 64,
    parameter int W    = 16
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            a_sgn_i,
    input  logic            b_sgn_i,
    input  logic            rnd_i,
    output logic [XLEN-1:0] word_o
);
    localparam int NL = XLEN / W;

    for (genvar k = 0; k < NL; k++) begin : g_lane
        pmulh_lane #(.W(W)) u_lane (
            .a_i     (a_i[k*W +: W]),
            .b_i     (b_i[k*W +: W]),
            .a_sgn_i (a_sgn_i),
            .b_sgn_i (b_sgn_i),
            .rnd_i   (rnd_i),
            .hi_o    (word_o[k*W +: W])
        );
    end

endmodule

// File: rtl/pmulh_round_unit.sv
// Module: top of the packed rounding multiply-high unit.
// It runs a 16-bit lane bank and, when XLEN >= 64, a 32-bit lane bank in
// parallel, selects one by lane width, forces zero on an illegal
// configuration, and registers the result and the illegal flag.
// Assumes: XLEN is 32 or 64; synchronous active-low reset.
module pmulh_round_unit #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] op_a_i,
    input  logic [XLEN-1:0] op_b_i,
    input  logic            lane32_i,
    input  logic [1:0]      mode_i,
    input  logic            round_i,
    output logic [XLEN-1:0] result_o,
    output logic            illegal_o
);
    import pmulh_pkg::*;

    localparam bit HAS_W32 = (XLEN >= 64);

    sign_mode_e      mode;
    logic            a_sgn;
    logic            b_sgn;
    logic [XLEN-1:0] word16;
    logic [XLEN-1:0] word32;
    logic            illegal_d;
    logic [XLEN-1:0] result_d;

    // Decode the signedness of each factor from the mode
    always_comb begin
        mode  = sign_mode_e'(mode_i);
        a_sgn = a_is_signed(mode);
        b_sgn = b_is_signed(mode);
    end

    pmulh_bank #(.XLEN(XLEN), .W(16)) u_bank16 (
        .a_i     (op_a_i),
        .b_i     (op_b_i),
        .a_sgn_i (a_sgn),
        .b_sgn_i (b_sgn),
        .rnd_i   (round_i),
        .word_o  (word16)
    );

    if (HAS_W32) begin : g_w32
        pmulh_bank #(.XLEN(XLEN), .W(32)) u_bank32 (
            .a_i     (op_a_i),
            .b_i     (op_b_i),
            .a_sgn_i (a_sgn),
            .b_sgn_i (b_sgn),
            .rnd_i   (round_i),
            .word_o  (word32)
        );
    end else begin : g_no_w32
        assign word32 = '0;
    end

    // Flag illegal configurations and select the lane bank
    always_comb begin
        illegal_d = (mode == MODE_RSVD) || (lane32_i && !HAS_W32);
        if (illegal_d)     result_d = '0;
        else if (lane32_i) result_d = word32;
        else               result_d = word16;
    end

    // Register the result and flag, clearing both on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o  <= '0;
            illegal_o <= 1'b0;
        end else begin
            result_o  <= result_d;
            illegal_o <= illegal_d;
        end
    end

    // R11: an illegal request produces a zero word
    p_illegal_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (result_o == '0));

    // R11: an illegal request raises the flag one cycle later
    p_illegal_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == 2'b11) || (lane32_i && !HAS_W32)) |=> illegal_o);

    // R12: a zero first operand gives a zero word on a legal request
    p_zero_operand_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_a_i == '0) && (mode_i != 2'b11) && !(lane32_i && !HAS_W32))
        |=> (result_o == '0));

    // R9: inputs held over two edges keep the output unchanged
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(op_a_i) && $stable(op_b_i) && $stable(mode_i)
         && $stable(lane32_i) && $stable(round_i))
        |=> ($stable(result_o) && $stable(illegal_o)));

endmodule

// File: tb/pmulh_round_unit_test.sv
module pmulh_round_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    logic        l32 = 1'b0;
    logic [1:0]  md = 2'b00;
    logic        rnd = 1'b0;
    logic [63:0] res64;
    logic        ill64;
    logic [31:0] res32;
    logic        ill32;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmulh_round_unit #(.XLEN(64)) uut (
        .clk(clk), .rst_n(rst_n), .op_a_i(a), .op_b_i(b), .lane32_i(l32),
        .mode_i(md), .round_i(rnd), .result_o(res64), .illegal_o(ill64));

    pmulh_round_unit #(.XLEN(32)) uut32 (
        .clk(clk), .rst_n(rst_n), .op_a_i(a[31:0]), .op_b_i(b[31:0]),
        .lane32_i(l32), .mode_i(md), .round_i(rnd), .result_o(res32),
        .illegal_o(ill32));

    // Exact reference for one lane of width w
    function automatic logic [31:0] ref_lane(int w, logic [31:0] x, logic [31:0] y,
                                             logic sx, logic sy, logic r);
        logic signed [127:0] ex, ey, p;
        logic [127:0] q;
        logic [31:0] o;
        ex = '0; ey = '0; o = '0;
        for (int i = 0; i < 128; i++) begin
            ex[i] = (i < w) ? x[i] : (sx & x[w-1]);
            ey[i] = (i < w) ? y[i] : (sy & y[w-1]);
        end
        p = ex * ey;
        if (r) p = p + (128'sd1 <<< (w - 1));
        q = p;
        q = q >> w;
        for (int i = 0; i < w; i++) o[i] = q[i];
        return o;
    endfunction

    // Reference for a whole word of width xlen
    function automatic logic [63:0] model(int xlen, logic [63:0] x, logic [63:0] y,
                                          logic w32, logic [1:0] m, logic r,
                                          output logic il);
        int w;
        logic [63:0] o;
        logic [31:0] lv;
        w  = w32 ? 32 : 16;
        il = (m == 2'b11) || (w32 && xlen < 64);
        o  = '0;
        if (!il) begin
            for (int k = 0; k < xlen / w; k++) begin
                lv = ref_lane(w, 32'(x >> (k * w)), 32'(y >> (k * w)),
                              (m == 2'b00) || (m == 2'b10), (m == 2'b00), r);
                for (int i = 0; i < w; i++) o[k*w + i] = lv[i];
            end
        end
        return o;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one vector, then compare both instances after the capturing edge
    task automatic run_vec(string tag, logic [63:0] x, logic [63:0] y,
                           logic w32, logic [1:0] m, logic r);
        logic [63:0] e64, e32;
        logic i64, i32;
        @(negedge clk);
        a = x; b = y; l32 = w32; md = m; rnd = r;
        e64 = model(64, x, y, w32, m, r, i64);
        e32 = model(32, x, y, w32, m, r, i32);
        @(negedge clk);
        check({tag, " xlen64"}, res64, e64);
        check({tag, " xlen64 flag R11"}, {63'd0, ill64}, {63'd0, i64});
        check({tag, " xlen32"}, {32'd0, res32}, e32);
        check({tag, " xlen32 flag R11"}, {63'd0, ill32}, {63'd0, i32});
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        logic [63:0] e, e1, e2, ex_a;
        logic il;
        void'($urandom(32'd20240611));

        // R10: reset clears outputs
        a = 64'hFFFF_FFFF_FFFF_FFFF; b = a; md = 2'b11;
        repeat (3) @(negedge clk);
        check("R10 result", res64, 64'd0);
        check("R10 flag", {63'd0, ill64}, 64'd0);
        check("R10 result32", {32'd0, res32}, 64'd0);
        rst_n = 1'b1;

        // R8: most negative squared, all-ones squared
        run_vec("R8 R3 minneg", 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 1'b0, 2'b00, 1'b1);
        check("R8 lane value 0x4000", res64, 64'h4000_4000_4000_4000);
        run_vec("R8 R4 allones", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'b01, 1'b1);
        check("R8 lane value 0xFFFE", res64, 64'hFFFE_FFFE_FFFE_FFFE);
        run_vec("R8 R2 minneg w32", 64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000, 1'b1, 2'b00, 1'b1);
        run_vec("R8 R2 allones w32", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'b01, 1'b1);

        // R6/R7: product low half exactly on the threshold
        run_vec("R6 threshold", 64'h0001_0001_0001_0001, 64'h8000_8000_8000_8000, 1'b0, 2'b01, 1'b1);
        check("R6 rounds up", res64, 64'h0001_0001_0001_0001);
        run_vec("R7 threshold trunc", 64'h0001_0001_0001_0001, 64'h8000_8000_8000_8000, 1'b0, 2'b01, 1'b0);
        check("R7 truncates", res64, 64'd0);
        run_vec("R6 threshold w32", 64'h0000_0001_0000_0001, 64'h8000_0000_8000_0000, 1'b1, 2'b01, 1'b1);
        check("R6 rounds up w32", res64, 64'h0000_0001_0000_0001);

        // R5: mixed mode is not commutative
        run_vec("R5 mixed", 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0002, 1'b0, 2'b10, 1'b0);
        e1 = res64;
        run_vec("R5 mixed swapped", 64'h0000_0000_0000_0002, 64'h0000_0000_0000_FFFF, 1'b0, 2'b10, 1'b0);
        e2 = res64;
        n_chk++;
        if (e1 === e2) begin
            n_bad++;
            $display("FAIL R5 swap: actual %h expected not %h", e2, e1);
        end

        // R1: lanes independent, one lane active
        run_vec("R1 single lane", 64'h0000_7FFF_0000_0000, 64'h0000_7FFF_0000_0000, 1'b0, 2'b00, 1'b0);
        check("R1 isolated", res64, 64'h0000_3FFF_0000_0000);

        // R12: zero operand, all modes and rounding
        for (int m = 0; m < 3; m++) begin
            run_vec("R12 zero", 64'd0, 64'h8000_FFFF_1234_8000, 1'b0, 2'(m), 1'b1);
            check("R12 zero word", res64, 64'd0);
        end

        // R11: reserved mode and 32-bit lanes on a 32-bit datapath
        run_vec("R11 reserved", 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b0, 2'b11, 1'b1);
        run_vec("R11 w32 on xlen32", 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b1, 2'b00, 1'b0);
        check("R11 xlen32 flag set", {63'd0, ill32}, 64'd1);

        // R9: output unchanged before the capturing edge
        run_vec("R9 first", 64'h0100_0100_0100_0100, 64'h0300_0300_0300_0300, 1'b0, 2'b01, 1'b0);
        e = model(64, 64'h0100_0100_0100_0100, 64'h0300_0300_0300_0300, 1'b0, 2'b01, 1'b0, il);
        @(negedge clk);
        a = 64'h7FFF_7FFF_7FFF_7FFF; b = a; md = 2'b00; rnd = 1'b1;
        #1;
        check("R9 before edge", res64, e);
        ex_a = model(64, a, b, 1'b0, 2'b00, 1'b1, il);
        @(negedge clk);
        check("R9 after edge", res64, ex_a);

        // R1..R7: constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [63:0] x, y;
            logic w32, r;
            logic [1:0] m;
            x   = {$urandom, $urandom};
            y   = {$urandom, $urandom};
            w32 = 1'($urandom);
            r   = 1'($urandom);
            m   = (($urandom % 16) == 0) ? 2'b11 : 2'($urandom % 3);
            run_vec($sformatf("rand %s %s %s", w32 ? "R2" : "R1",
                              (m == 2'b00) ? "R3" : (m == 2'b01) ? "R4" :
                              (m == 2'b10) ? "R5" : "R11",
                              r ? "R6" : "R7"), x, y, w32, m, r);
        end

        done = 1'b1;
        report();
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            report();
            $finish;
        end
    end

endmodule